// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block holds the configuration registers of a legacy Super I/O function. Software reaches them through two adjacent byte addresses on a synchronous ISA-style I/O bus. The lower address holds a selector, the upper address moves data, and the whole file has 256 byte registers. A write to the selector address picks a register. A read or write at the data address then acts on that register.

Only some selector values lead to registers that can be written. The rest, an irregular set of ranges and single values, ignore writes and keep their reset contents. A few registers reset to fixed values: an identification code, a function-select setting and the base addresses of the floppy, parallel and serial functions. Everything else resets to zero.

The decode window stays closed after reset. It opens and closes under one bit of a byte in the host bridge's configuration space. The block watches the bridge's configuration write strobe and updates its enable on every write to that byte. While the window is closed, bus accesses have no effect on the block and reads return 0xFF.

Top module: `sio_cfg_port`

## Requirements
- R1: A write at the selector address (0x3F0) with the window open stores the write byte as the current selector, which resets to 0x00.
- R2: A read strobe with the window open loads io_rdata, at the clock edge that samples the strobe, with the register chosen by the current selector. io_rdata keeps its value in every cycle that has no read strobe, and it resets to 0xFF.
- R3: A write at the data address (0x3F1) is discarded when the selector is in 0x00–0xDF, or is 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: A write at the data address with any other selector (0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8, 0xFC) replaces that register, and later reads return the new byte.
- R5: After reset, register 0xE0 holds 0x3C, 0xE2 holds 0x03, 0xE3 holds 0xFC, 0xE6 holds 0xDE, 0xE7 holds 0xFE and 0xE8 holds 0xBE. Every other register holds 0x00.
- R6: The window is closed after reset.
- R7: A bridge configuration write to offset 0x85 sets the window enable to bit 1 of the written byte (1 = open). Bridge configuration writes to any other offset leave the enable unchanged.
- R8: While the window is closed, a read or write at either address changes neither the selector nor any register, and a read loads 0xFF.
- R9: An access outside the two-address pair has no effect, and a read there loads 0xFF.
- R10: A read at the selector address returns the selected register, the same as a read at the data address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O bus address |
| io_wdata | input | 8 | I/O write byte |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rdata | output | 8 | Registered read byte |
| cfg_wr | input | 1 | Host bridge configuration write strobe |
| cfg_off | input | 8 | Host bridge configuration byte offset |
| cfg_data | input | 8 | Host bridge configuration write byte |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address, a base of 0x3F0, an 8-bit selector and the enable at bit 1 of bridge offset 0x85. With an 8-bit selector, the bench can walk all 256 registers in a single run. For each selector it checks the reset contents, then two write patterns against its own table of protected indexes. The same settings let it probe neighbouring addresses and other bridge offsets. This shows that only the two bytes of the pair and the single bridge byte have any effect.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef logic [7:0] byte_t;

  // Writable selectors; all others discard data writes.
  function automatic bit reg_writable(int unsigned i);
    case (i)
      8'hE0, 8'hE1, 8'hE2, 8'hE3,
      8'hE6, 8'hE7, 8'hE8,
      8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
      8'hF4, 8'hF6, 8'hF8, 8'hFC: return 1'b1;
      default:                     return 1'b0;
    endcase
  endfunction

  // Fixed contents after reset.
  function automatic byte_t reg_init(int unsigned i);
    case (i)
      8'hE0:   return 8'h3C;  // identification
      8'hE2:   return 8'h03;  // function select
      8'hE3:   return 8'hFC;  // floppy base
      8'hE6:   return 8'hDE;  // parallel base
      8'hE7:   return 8'hFE;  // first serial base
      8'hE8:   return 8'hBE;  // second serial base
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_win_decode.sv
module sio_win_decode #(
  parameter int          ADDR_W      = 16,
  parameter int          OFF_W       = 8,
  parameter int          CFG_W       = 8,
  parameter logic [15:0] BASE        = 16'h03F0,
  parameter logic [7:0]  GATE_OFFSET = 8'h85,
  parameter int          GATE_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic              win_en,
  output logic              hit,
  output logic              idx_we,
  output logic              dat_we
);

  localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE) + ADDR_W'(1);

  logic gate_hit;
  logic at_idx, at_dat;

  assign gate_hit = cfg_wr && (cfg_off == OFF_W'(GATE_OFFSET));

  always_ff @(posedge clk) begin
    if (rst)           win_en <= 1'b0;
    else if (gate_hit) win_en <= cfg_data[GATE_BIT];
  end

  assign at_idx = (io_addr == IDX_ADDR);
  assign at_dat = (io_addr == DAT_ADDR);
  assign hit    = win_en && (at_idx || at_dat);
  assign idx_we = win_en && at_idx && io_wr;
  assign dat_we = win_en && at_dat && io_wr;

  p_gate_follow_r7: assert property (@(posedge clk) disable iff (rst)
    gate_hit |=> (win_en == $past(cfg_data[GATE_BIT])));

  p_gate_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !gate_hit |=> $stable(win_en));

  p_no_strobe_when_closed_r8: assert property (@(posedge clk) disable iff (rst)
    !win_en |-> !(idx_we || dat_we || hit));

  p_single_target_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({idx_we, dat_we}) <= 1);

  logic unused_rd;
  assign unused_rd = io_rd;

endmodule

// File: rtl/sio_index_reg.sv
module sio_index_reg #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] idx
);

  always_ff @(posedge clk) begin
    if (rst)         idx <= '0;
    else if (idx_we) idx <= wdata;
  end

  p_idx_load_r1: assert property (@(posedge clk) disable iff (rst)
    idx_we |=> (idx == $past(wdata)));

  p_idx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !idx_we |=> $stable(idx));

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val
);

  localparam int NUM = 1 << IDX_W;

  logic [NUM*DATA_W-1:0] regs_flat;

  for (genvar g = 0; g < NUM; g++) begin : g_cell
    localparam logic [DATA_W-1:0] INIT = DATA_W'(sio_pkg::reg_init(g));
    if (sio_pkg::reg_writable(g)) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                  q <= INIT;
        else if (wr_en && idx == IDX_W'(g))       q <= wdata;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;
    end else begin : g_ro
      assign regs_flat[g*DATA_W +: DATA_W] = INIT;
    end
  end

  assign rd_val = regs_flat[idx*DATA_W +: DATA_W];

  p_ro_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sio_pkg::reg_writable(int'(idx))) |=> $stable(regs_flat));

  p_no_write_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_flat));

  p_rw_update_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sio_pkg::reg_writable(int'(idx))) |=> (rd_val == $past(wdata)));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          IDX_W       = 8,
  parameter int          OFF_W       = 8,
  parameter logic [15:0] BASE        = 16'h03F0,
  parameter logic [7:0]  GATE_OFFSET = 8'h85,
  parameter int          GATE_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [DATA_W-1:0] cfg_data
);

  localparam logic [DATA_W-1:0] IDLE = '1;

  logic              win_en, hit, idx_we, dat_we;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_val;

  sio_win_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CFG_W(DATA_W), .BASE(BASE),
    .GATE_OFFSET(GATE_OFFSET), .GATE_BIT(GATE_BIT)
  ) u_dec (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_data(cfg_data),
    .win_en(win_en), .hit(hit), .idx_we(idx_we), .dat_we(dat_we)
  );

  sio_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .idx_we(idx_we),
    .wdata(io_wdata[IDX_W-1:0]), .idx(idx)
  );

  sio_reg_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .idx(idx), .wr_en(dat_we),
    .wdata(io_wdata), .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= IDLE;
    else if (io_rd) io_rdata <= hit ? rd_val : IDLE;
  end

  p_idle_read_r8: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !hit) |=> (io_rdata == IDLE));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

  p_hit_read_r10: assert property (@(posedge clk) disable iff (rst)
    (io_rd && hit) |=> (io_rdata == $past(rd_val)));

endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_off = '0;
  logic [7:0]  cfg_data = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [15:0] IA = 16'h03F0;
  localparam logic [15:0] DA = 16'h03F1;

  always #4 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_data(cfg_data)
  );

  function automatic bit exp_wr(int i);
    if (i < 8'hE0) return 1'b0;
    if (i inside {8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5, 8'hF7,
                  [8'hF9:8'hFB], [8'hFD:8'hFF]}) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] exp_rst(int i);
    case (i)
      8'hE0: return 8'h3C;
      8'hE2: return 8'h03;
      8'hE3: return 8'hFC;
      8'hE6: return 8'hDE;
      8'hE7: return 8'hFE;
      8'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic cfg_write(logic [7:0] o, logic [7:0] d);
    @(negedge clk);
    cfg_off = o; cfg_data = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_closed();
    logic [7:0] v;
    do_reset();
    check("R2 rdata reset", io_rdata, 8'hFF);
    io_write(IA, 8'hE0);
    io_read(DA, v);
    check("R6 closed after reset", v, 8'hFF);
    cfg_write(8'h85, 8'h02);
    io_read(DA, v);
    check("R1 selector resets to 00 (closed write ignored)", v, 8'h00);
  endtask

  task automatic t_reset_values();
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      io_write(IA, 8'(i));
      io_read(DA, v);
      check($sformatf("R5 reset value idx %02h", i), v, exp_rst(i));
    end
  endtask

  task automatic t_sweep(logic [7:0] pat);
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      io_write(IA, 8'(i));
      io_write(DA, pat ^ 8'(i));
      io_read(DA, v);
      if (exp_wr(i)) check($sformatf("R4 writable idx %02h", i), v, pat ^ 8'(i));
      else           check($sformatf("R3 protected idx %02h", i), v, exp_rst(i));
    end
  endtask

  task automatic t_index_read();
    logic [7:0] v;
    io_write(IA, 8'hF4);
    io_write(DA, 8'h77);
    io_read(IA, v);
    check("R10 read at selector address", v, 8'h77);
    io_write(IA, 8'hE6);
    io_read(IA, v);
    check("R1 selector switched", v, 8'hDE);
  endtask

  task automatic t_rdata_hold();
    logic [7:0] v;
    io_write(IA, 8'hF6);
    io_write(DA, 8'h11);
    io_read(DA, v);
    check("R2 read value", v, 8'h11);
    io_write(DA, 8'h22);
    repeat (2) @(negedge clk);
    check("R2 rdata holds without strobe", io_rdata, 8'h11);
    io_read(DA, v);
    check("R2 new read", v, 8'h22);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    io_write(IA, 8'hE7);
    cfg_write(8'h84, 8'h00);
    cfg_write(8'h05, 8'h00);
    io_read(DA, v);
    check("R7 other offsets ignored", v, 8'hFE);
    cfg_write(8'h85, 8'hFD);
    io_read(DA, v);
    check("R7 bit1 clear closes", v, 8'hFF);
    cfg_write(8'h84, 8'h02);
    io_read(DA, v);
    check("R7 other offset does not open", v, 8'hFF);
    cfg_write(8'h85, 8'h02);
    io_read(DA, v);
    check("R7 bit1 set opens", v, 8'hFE);
  endtask

  task automatic t_closed_side_effects();
    logic [7:0] v;
    io_write(IA, 8'hE6);
    cfg_write(8'h85, 8'h00);
    io_write(IA, 8'hE7);
    io_write(DA, 8'h5A);
    io_read(IA, v);
    check("R8 closed read at selector", v, 8'hFF);
    cfg_write(8'h85, 8'h02);
    io_read(DA, v);
    check("R8 no selector or data change while closed", v, 8'hDE);
    io_write(IA, 8'hE7);
    io_read(DA, v);
    check("R8 E7 untouched while closed", v, 8'hFE);
  endtask

  task automatic t_outside();
    logic [7:0] v;
    io_write(IA, 8'hE8);
    io_write(16'h03F2, 8'hE0);
    io_write(16'h02F1, 8'h33);
    io_write(16'h03EF, 8'hE0);
    io_read(16'h03F2, v);
    check("R9 read outside pair", v, 8'hFF);
    io_read(DA, v);
    check("R9 outside accesses no effect", v, 8'hBE);
  endtask

  initial begin
    t_reset_closed();
    t_reset_values();
    t_sweep(8'hA5);
    t_sweep(8'h5A);
    do_reset();
    cfg_write(8'h85, 8'h02);
    t_index_read();
    t_rdata_hold();
    t_gate();
    t_closed_side_effects();
    t_outside();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule